// File: doc/BRIEF.md
# Register-Target Conditional Branch and Link Unit

This block handles the two control-transfer opcodes of a small 32-bit load/store processor. Each time the execute strobe is high it looks at the instruction word, the already-incremented program counter, and two register values fetched for it: the jump target and the value under test. From these it decides whether the program counter is redirected. The target always comes from a register and never from an immediate field. A 3-bit condition code in the low bits of the instruction selects the test applied to the second register.

The linking opcode also asks for a register write of the incremented program counter. This write happens whether or not the branch is taken, so a linking branch with the "never" condition acts as a plain save of the return address. All results are registered and appear one clock after the strobe. The link value is always the program counter as it was before any redirect. The register file and fetch path sit outside this block.

Top module: `brlink_unit`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, next_pc_o, taken_o, link_we_o, link_idx_o and link_val_o are all zero.
- R2: Outputs change only at the clock edge that samples exec_i high. At any edge with exec_i low, taken_o and link_we_o go low, and next_pc_o, link_idx_o and link_val_o hold their values.
- R3: The opcode is instruction bits 31..27. Value 8 is branch, value 9 is branch-and-link. Any other opcode gives taken_o low, link_we_o low and next_pc_o equal to pc_inc_i.
- R4: The condition code is instruction bits 2..0. Code 000 never takes the branch. Code 001 always takes it.
- R5: Code 010 takes the branch when the test value is all zeros. Code 011 takes it when the test value is not zero.
- R6: Code 100 takes the branch when bit 31 of the test value is 0. Code 101 takes it when bit 31 is 1.
- R7: Codes 110 and 111 never take the branch.
- R8: When the branch is taken, next_pc_o equals tgt_val_i. Otherwise it equals pc_inc_i.
- R9: Opcode 9 always raises link_we_o, whatever the condition or its outcome. link_idx_o then equals instruction bits 26..22, and link_val_o equals pc_inc_i as presented, never the redirected target.
- R10: Opcode 8 never raises link_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; the inputs below are sampled when it is high |
| instr_i | input | 32 | Instruction word |
| pc_inc_i | input | 32 | Program counter already advanced past this instruction |
| tgt_val_i | input | 32 | Value of the target register |
| tst_val_i | input | 32 | Value of the register under test |
| next_pc_o | output | 32 | Program counter to use next |
| taken_o | output | 1 | High for one cycle when a branch was taken |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Index of the link register |
| link_val_o | output | 32 | Value to write into the link register |

## Verification
The assertions compare each output against the inputs sampled one edge earlier. They assume those inputs are stable around the sampling edge, and they arm only after one full cycle out of reset. The bench drives every input on the falling edge and holds it through the next rising edge. It never raises the strobe during reset. This keeps the one-edge relationship exact. Between strobes the bench changes the inputs freely, to show that the outputs hold.

// File: rtl/brlink_pkg.sv
package brlink_pkg;

  localparam int unsigned OPC_W   = 5;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned COND_W  = 3;

  localparam logic [OPC_W-1:0] OPC_BRANCH = 5'd8;
  localparam logic [OPC_W-1:0] OPC_LINK   = 5'd9;

  typedef enum logic [COND_W-1:0] {
    CND_NEVER  = 3'd0,
    CND_ALWAYS = 3'd1,
    CND_ZERO   = 3'd2,
    CND_NONZ   = 3'd3,
    CND_POS    = 3'd4,
    CND_NEG    = 3'd5,
    CND_RSV6   = 3'd6,
    CND_RSV7   = 3'd7
  } cond_e;

  // Outcome of a condition code given the zero flag and sign bit of the tested value.
  function automatic logic cond_met(input cond_e code, input logic is_zero, input logic sign);
    case (code)
      CND_ALWAYS: cond_met = 1'b1;
      CND_ZERO:   cond_met = is_zero;
      CND_NONZ:   cond_met = !is_zero;
      CND_POS:    cond_met = !sign;
      CND_NEG:    cond_met = sign;
      default:    cond_met = 1'b0;
    endcase
  endfunction

  // Next program counter: target when taken, fall-through otherwise.
  function automatic logic [31:0] pick_pc(input logic hit, input logic [31:0] fall,
                                          input logic [31:0] tgt);
    pick_pc = hit ? tgt : fall;
  endfunction

endpackage

// File: rtl/brlink_decode.sv
module brlink_decode
  import brlink_pkg::*;
#(
  parameter int unsigned IW      = 32,
  parameter int unsigned OPC_LSB = 27,
  parameter int unsigned RA_LSB  = 22
) (
  input  logic [IW-1:0]    instr_i,
  output logic             is_br_o,
  output logic             is_brl_o,
  output logic [IDX_W-1:0] ra_o,
  output cond_e            cond_o
);
  logic [OPC_W-1:0] opc;
  logic             unused_fields;

  assign opc           = instr_i[OPC_LSB +: OPC_W];
  assign ra_o          = instr_i[RA_LSB +: IDX_W];
  assign cond_o        = cond_e'(instr_i[COND_W-1:0]);
  assign is_br_o       = (opc == OPC_BRANCH);
  assign is_brl_o      = (opc == OPC_LINK);
  assign unused_fields = ^instr_i[RA_LSB-1:COND_W];
endmodule

// File: rtl/brlink_cond.sv
module brlink_cond
  import brlink_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] tst_i,
  input  cond_e           cond_i,
  output logic            hit_o
);
  logic is_zero;
  logic sign;

  assign is_zero = (tst_i == '0);
  assign sign    = tst_i[XLEN-1];
  assign hit_o   = cond_met(cond_i, is_zero, sign);
endmodule

// File: rtl/brlink_unit.sv
module brlink_unit
  import brlink_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  pc_inc_i,
  input  logic [XLEN-1:0]  tgt_val_i,
  input  logic [XLEN-1:0]  tst_val_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             link_we_o,
  output logic [IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_val_o
);
  logic             is_br, is_brl;
  logic [IDX_W-1:0] ra;
  cond_e            cond;
  logic             cond_hit;
  logic             take_now;

  brlink_decode #(.IW(XLEN)) u_dec (
    .instr_i (instr_i),
    .is_br_o (is_br),
    .is_brl_o(is_brl),
    .ra_o    (ra),
    .cond_o  (cond)
  );

  brlink_cond #(.XLEN(XLEN)) u_cond (
    .tst_i (tst_val_i),
    .cond_i(cond),
    .hit_o (cond_hit)
  );

  assign take_now = (is_br || is_brl) && cond_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_o  <= '0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_idx_o <= '0;
      link_val_o <= '0;
    end else if (exec_i) begin
      next_pc_o  <= pick_pc(take_now, pc_inc_i, tgt_val_i);
      taken_o    <= take_now;
      link_we_o  <= is_brl;
      link_idx_o <= ra;
      link_val_o <= pc_inc_i;
    end else begin
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/brlink_chk.sv
module brlink_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exec_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] pc_inc_i,
  input logic [XLEN-1:0] tgt_val_i,
  input logic            cond_hit,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [4:0]      link_idx_o,
  input logic [XLEN-1:0] link_val_o
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(exec_i)) |-> (!taken_o && !link_we_o && $stable(next_pc_o)
                                   && $stable(link_val_o) && $stable(link_idx_o)));

  // R3
  other_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exec_i) && $past(instr_i[31:27]) != 5'd8 && $past(instr_i[31:27]) != 5'd9)
      |-> (!taken_o && !link_we_o && next_pc_o == $past(pc_inc_i)));

  // R4
  always_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exec_i) && $past(instr_i[2:0]) == 3'd1
     && ($past(instr_i[31:27]) == 5'd8 || $past(instr_i[31:27]) == 5'd9)) |-> taken_o);

  // R7
  rsv_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exec_i) && $past(instr_i[2:1]) == 2'b11) |-> !taken_o);

  // R8
  taken_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o) |-> (next_pc_o == $past(tgt_val_i) && $past(cond_hit)));

  // R8
  fall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exec_i) && !taken_o) |-> (next_pc_o == $past(pc_inc_i)));

  // R9
  link_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exec_i) && $past(instr_i[31:27]) == 5'd9)
      |-> (link_we_o && link_idx_o == $past(instr_i[26:22]) && link_val_o == $past(pc_inc_i)));

  // R10
  no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(exec_i) && $past(instr_i[31:27]) == 5'd8) |-> !link_we_o);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_out_chk: assert (!taken_o && !link_we_o);
    end
  end
endmodule

bind brlink_unit brlink_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exec_i    (exec_i),
  .instr_i   (instr_i),
  .pc_inc_i  (pc_inc_i),
  .tgt_val_i (tgt_val_i),
  .cond_hit  (cond_hit),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .link_we_o (link_we_o),
  .link_idx_o(link_idx_o),
  .link_val_o(link_val_o)
);

// File: tb/sim_brlink_unit.sv
module sim_brlink_unit;
  localparam int VW = 47;
  localparam int NV = 18;
  // {opcode, cond, ra, test value, expect taken, expect link}
  localparam logic [VW-1:0] TBL [0:NV-1] = '{
    {5'd8,  3'd1, 5'd0,  32'h0000_0000, 1'b1, 1'b0},
    {5'd8,  3'd0, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {5'd8,  3'd2, 5'd0,  32'h0000_0000, 1'b1, 1'b0},
    {5'd8,  3'd2, 5'd0,  32'h0000_0001, 1'b0, 1'b0},
    {5'd8,  3'd3, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {5'd8,  3'd3, 5'd0,  32'h8000_0000, 1'b1, 1'b0},
    {5'd8,  3'd4, 5'd0,  32'h7FFF_FFFF, 1'b1, 1'b0},
    {5'd8,  3'd4, 5'd0,  32'h8000_0000, 1'b0, 1'b0},
    {5'd8,  3'd5, 5'd0,  32'h8000_0000, 1'b1, 1'b0},
    {5'd8,  3'd5, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {5'd8,  3'd6, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {5'd8,  3'd7, 5'd0,  32'h8000_0000, 1'b0, 1'b0},
    {5'd9,  3'd0, 5'd31, 32'h0000_0000, 1'b0, 1'b1},
    {5'd9,  3'd1, 5'd6,  32'h1234_5678, 1'b1, 1'b1},
    {5'd9,  3'd2, 5'd1,  32'h0000_0005, 1'b0, 1'b1},
    {5'd12, 3'd1, 5'd3,  32'h0000_0000, 1'b0, 1'b0},
    {5'd0,  3'd1, 5'd4,  32'h0000_0000, 1'b0, 1'b0},
    {5'd9,  3'd6, 5'd0,  32'h0000_0000, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [31:0] instr_i = '0, pc_inc_i = '0, tgt_val_i = '0, tst_val_i = '0;
  logic [31:0] next_pc_o, link_val_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  brlink_unit u0 (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i),
    .pc_inc_i(pc_inc_i), .tgt_val_i(tgt_val_i), .tst_val_i(tst_val_i),
    .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_val_o(link_val_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string cond_req(input logic [4:0] opc, input logic [2:0] c);
    if (opc != 5'd8 && opc != 5'd9) return "R3";
    if (c <= 3'd1) return "R4";
    if (c <= 3'd3) return "R5";
    if (c <= 3'd5) return "R6";
    return "R7";
  endfunction

  // Present one instruction for one edge, then sample after that edge.
  task automatic issue(input logic [4:0] opc, input logic [2:0] c, input logic [4:0] ra,
                       input logic [31:0] tst, input logic [31:0] pc, input logic [31:0] tgt);
    @(negedge clk);
    exec_i    = 1'b1;
    instr_i   = {opc, ra, 5'd3, 5'd7, 9'h155, c};
    pc_inc_i  = pc;
    tgt_val_i = tgt;
    tst_val_i = tst;
    @(negedge clk);
    exec_i    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(next_pc_o == 0 && link_val_o == 0, "R1", next_pc_o, 0);
    check(!taken_o && !link_we_o && link_idx_o == 0, "R1", {taken_o, link_we_o, link_idx_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(next_pc_o == 0 && !taken_o && !link_we_o, "R1", next_pc_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [4:0]  opc;
      logic [2:0]  c;
      logic [4:0]  ra;
      logic [31:0] tst, pc, tgt, exp_pc;
      logic        et, ew;
      {opc, c, ra, tst, et, ew} = TBL[i];
      pc  = 32'h0000_1000 + 32'(i) * 4;
      tgt = 32'h8000_0000 | (32'(i) << 8);
      issue(opc, c, ra, tst, pc, tgt);
      exp_pc = et ? tgt : pc;
      check(taken_o == et, cond_req(opc, c), {31'd0, taken_o}, {31'd0, et});
      check(next_pc_o == exp_pc, "R8", next_pc_o, exp_pc);
      check(link_we_o == ew, opc == 5'd8 ? "R10" : "R9", {31'd0, link_we_o}, {31'd0, ew});
      if (ew) begin
        check(link_idx_o == ra, "R9", {27'd0, link_idx_o}, {27'd0, ra});
        check(link_val_o == pc, "R9", link_val_o, pc);
      end
    end

    // R2: strobe low clears the flags and holds the values
    issue(5'd9, 3'd1, 5'd17, 32'h0, 32'h0000_2000, 32'h0000_4444);
    check(taken_o && link_we_o && next_pc_o == 32'h4444, "R2", next_pc_o, 32'h4444);
    instr_i   = {5'd8, 5'd2, 19'd0, 3'd1};
    pc_inc_i  = 32'hDEAD_0000;
    tgt_val_i = 32'hBEEF_0000;
    @(negedge clk);
    check(!taken_o && !link_we_o, "R2", {30'd0, taken_o, link_we_o}, 0);
    check(next_pc_o == 32'h4444, "R2", next_pc_o, 32'h4444);
    check(link_val_o == 32'h2000 && link_idx_o == 5'd17, "R2", link_val_o, 32'h2000);

    // R9: back-to-back linking with the target equal to a different value
    issue(5'd9, 3'd3, 5'd2, 32'h1, 32'h0000_3004, 32'h0000_3004 + 32'h100);
    check(link_val_o == 32'h3004 && next_pc_o == 32'h3104, "R9", link_val_o, 32'h3004);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule